// File: doc/BRIEF.md
# Dock Set and Shift Executor

This block carries out the two register-writing instruction classes of a 26-bit dock instruction word. It holds an outer loop counter, an inner loop counter with an unbounded ("infinite") marker, a 37-bit data latch, and two user flags A and B. An instruction is applied on a clock edge when the execute strobe is high. A third flag, C, is supplied from outside and can only be read.

A *set* instruction writes exactly one destination. The destination is picked by a one-hot select, and a source code picks the value to write. A *shift* instruction moves a 19-bit immediate into the bottom of the data latch, and the old low bits move upward. Repeated shifts therefore build literals wider than one instruction can carry. The loop sequencer reads the counter registers straight from the outputs. Instruction sequencing, predicates and move instructions belong to other blocks.

Bit fields used below: `w[20:19]` is the class (`00` = shift, `10` = set). For set, `w[18:15]` is the destination and `w[14:12]` is the source. Bits `w[25:21]` form a header that this block ignores.

Top module: `dock_exec_top`

## Requirements
- R1: While `rst_n` is low, all outputs are zero after the next clock edge: counters zero, infinity marker clear, data latch zero, both flags zero.
- R2: When `exec_i` is low, no output changes on the clock edge, whatever the instruction word.
- R3: Set with destination `1000` writes the outer counter. Source `100` loads the immediate in `w[5:0]`. Source `010` loads the data latch bits [5:0]. Source `001` loads the counter minus one, and a counter already at zero stays at zero.
- R4: Set with destination `0100` writes the inner counter. Source `100` with `w[6]=0` loads `w[5:0]` and clears the infinity marker. Source `100` with `w[6]=1` sets the infinity marker and leaves the count unchanged. Source `010` loads data latch bits [5:0] and clears the marker.
- R5: Set with destination `0010` loads the data latch with the 14-bit immediate `w[13:0]`. The 23 bits above it are filled with copies of `w[14]` (0 gives zero-extension, 1 gives one-extension).
- R6: Shift (`w[20:19]=00`) makes the data latch equal to {old latch bits [17:0], `w[18:0]`}.
- R7: Set with destination `0001` updates the flags. The new A is formed from the mask `w[11:6]` and the new B from the mask `w[5:0]`. Each new flag is the OR of the old values selected by its mask, where mask bit 0 = A, bit 1 = not A, bit 2 = B, bit 3 = not B, bit 4 = C, bit 5 = not C. Both flags use the values held before the instruction. An all-zero mask gives 0.
- R8: Class `01` or `11`, a set destination that is not one-hot, and any source code not listed in R3 or R4 all leave every output unchanged.
- R9: A valid instruction changes only its own destination. All other registers keep their values.
- R10: Header bits `w[25:21]` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | Execute the present instruction word on this edge |
| insn_i | input | 26 | Instruction word |
| flag_c_i | input | 1 | External C flag, read by flag updates |
| olc_o | output | 6 | Outer loop counter |
| ilc_o | output | 6 | Inner loop counter |
| ilc_inf_o | output | 1 | Inner counter is infinite |
| data_o | output | 37 | Data latch |
| flag_a_o | output | 1 | User flag A |
| flag_b_o | output | 1 | User flag B |

## Verification
The bench decrements the outer counter past zero. A design that wraps would show 63 instead of 0. The bench shifts twice in a row with distinct patterns, which catches swapped upper/lower slices and an off-by-one shift amount. It applies flag masks whose answer depends on reading the old A while B is being written, so that a design that computes B from the new A gives a wrong B. It also sends non-one-hot destinations, undefined sources and stray header bits, each of which would corrupt a register in a decoder that matches too loosely.

// File: rtl/dock_exec_pkg.sv
package dock_exec_pkg;

    localparam int WORD_W   = 26;
    localparam int CNT_W    = 6;
    localparam int DL_W     = 37;
    localparam int SHIFT_W  = 19;
    localparam int SETIMM_W = 14;
    localparam int MASK_W   = 6;
    localparam int NFLAGS   = 2;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_OLC_IMM,
        OP_OLC_DL,
        OP_OLC_DEC,
        OP_ILC_IMM,
        OP_ILC_DL,
        OP_ILC_INF,
        OP_DL_SET,
        OP_FLAGS,
        OP_SHIFT
    } dock_op_e;

    typedef struct packed {
        logic [CNT_W-1:0] olc;
        logic [CNT_W-1:0] ilc;
        logic             ilc_inf;
        logic [DL_W-1:0]  dl;
        logic             fa;
        logic             fb;
    } dock_state_t;

endpackage

// File: rtl/dock_exec_decode.sv
module dock_exec_decode
    import dock_exec_pkg::*;
(
    input  logic       exec_i,
    input  logic [1:0] cls_i,
    input  logic [3:0] dest_i,
    input  logic [2:0] src_i,
    input  logic       inf_bit_i,
    output dock_op_e   op_o
);

    always_comb begin
        op_o = OP_NONE;
        if (exec_i) begin
            if (cls_i == 2'b00) begin
                op_o = OP_SHIFT;
            end else if (cls_i == 2'b10) begin
                unique case (dest_i)
                    4'b1000: begin
                        unique case (src_i)
                            3'b100:  op_o = OP_OLC_IMM;
                            3'b010:  op_o = OP_OLC_DL;
                            3'b001:  op_o = OP_OLC_DEC;
                            default: op_o = OP_NONE;
                        endcase
                    end
                    4'b0100: begin
                        unique case (src_i)
                            3'b100:  op_o = inf_bit_i ? OP_ILC_INF : OP_ILC_IMM;
                            3'b010:  op_o = OP_ILC_DL;
                            default: op_o = OP_NONE;
                        endcase
                    end
                    4'b0010: op_o = OP_DL_SET;
                    4'b0001: op_o = OP_FLAGS;
                    default: op_o = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dock_exec_latch.sv
module dock_exec_latch #(
    parameter int DL_W     = 37,
    parameter int SHIFT_W  = 19,
    parameter int SETIMM_W = 14
) (
    input  logic [DL_W-1:0]    dl_q_i,
    input  logic [SHIFT_W-1:0] imm_i,
    output logic [DL_W-1:0]    set_val_o,
    output logic [DL_W-1:0]    shift_val_o
);

    localparam int KEEP_W = DL_W - SHIFT_W;
    localparam int EXT_W  = DL_W - SETIMM_W;

    logic ext_bit;
    logic [SHIFT_W-SETIMM_W-2:0] unused_gap;

    assign ext_bit     = imm_i[SETIMM_W];
    assign unused_gap  = imm_i[SHIFT_W-1:SETIMM_W+1];
    assign set_val_o   = {{EXT_W{ext_bit}}, imm_i[SETIMM_W-1:0]};
    assign shift_val_o = {dl_q_i[KEEP_W-1:0], imm_i};

endmodule

// File: rtl/dock_exec_flag.sv
module dock_exec_flag #(
    parameter int MASK_W = 6
) (
    input  logic [MASK_W-1:0] mask_i,
    input  logic              a_i,
    input  logic              b_i,
    input  logic              c_i,
    output logic              flag_o
);

    logic [MASK_W-1:0] terms;

    assign terms  = {~c_i, c_i, ~b_i, b_i, ~a_i, a_i};
    assign flag_o = |(terms & mask_i);

endmodule

// File: rtl/dock_exec_top.sv
module dock_exec_top
    import dock_exec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                exec_i,
    input  logic [WORD_W-1:0]   insn_i,
    input  logic                flag_c_i,
    output logic [CNT_W-1:0]    olc_o,
    output logic [CNT_W-1:0]    ilc_o,
    output logic                ilc_inf_o,
    output logic [DL_W-1:0]     data_o,
    output logic                flag_a_o,
    output logic                flag_b_o
);

    dock_state_t st_q, st_d;
    dock_op_e    op;
    logic [DL_W-1:0]   dl_set_val, dl_shift_val;
    logic [NFLAGS-1:0] flag_new;
    logic [4:0]        unused_hdr;

    assign unused_hdr = insn_i[WORD_W-1:WORD_W-5];

    dock_exec_decode u_decode (
        .exec_i   (exec_i),
        .cls_i    (insn_i[20:19]),
        .dest_i   (insn_i[18:15]),
        .src_i    (insn_i[14:12]),
        .inf_bit_i(insn_i[6]),
        .op_o     (op)
    );

    dock_exec_latch #(
        .DL_W    (DL_W),
        .SHIFT_W (SHIFT_W),
        .SETIMM_W(SETIMM_W)
    ) u_latch (
        .dl_q_i     (st_q.dl),
        .imm_i      (insn_i[SHIFT_W-1:0]),
        .set_val_o  (dl_set_val),
        .shift_val_o(dl_shift_val)
    );

    // Flag index 0 is B (mask in low field), index 1 is A (mask in high field)
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        dock_exec_flag #(.MASK_W(MASK_W)) u_flag (
            .mask_i(insn_i[g*MASK_W +: MASK_W]),
            .a_i   (st_q.fa),
            .b_i   (st_q.fb),
            .c_i   (flag_c_i),
            .flag_o(flag_new[g])
        );
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_OLC_IMM: st_d.olc = insn_i[CNT_W-1:0];
            OP_OLC_DL:  st_d.olc = st_q.dl[CNT_W-1:0];
            OP_OLC_DEC: st_d.olc = (st_q.olc == '0) ? '0 : st_q.olc - CNT_W'(1);
            OP_ILC_IMM: begin
                st_d.ilc     = insn_i[CNT_W-1:0];
                st_d.ilc_inf = 1'b0;
            end
            OP_ILC_DL: begin
                st_d.ilc     = st_q.dl[CNT_W-1:0];
                st_d.ilc_inf = 1'b0;
            end
            OP_ILC_INF: st_d.ilc_inf = 1'b1;
            OP_DL_SET:  st_d.dl = dl_set_val;
            OP_SHIFT:   st_d.dl = dl_shift_val;
            OP_FLAGS: begin
                st_d.fa = flag_new[1];
                st_d.fb = flag_new[0];
            end
            default: ;
        endcase
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign olc_o     = st_q.olc;
    assign ilc_o     = st_q.ilc;
    assign ilc_inf_o = st_q.ilc_inf;
    assign data_o    = st_q.dl;
    assign flag_a_o  = st_q.fa;
    assign flag_b_o  = st_q.fb;

endmodule

// File: rtl/dock_exec_chk.sv
module dock_exec_chk
    import dock_exec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic [WORD_W-1:0] insn_i,
    input logic              flag_c_i,
    input logic [CNT_W-1:0]  olc_o,
    input logic [CNT_W-1:0]  ilc_o,
    input logic              ilc_inf_o,
    input logic [DL_W-1:0]   data_o,
    input logic              flag_a_o,
    input logic              flag_b_o
);

    logic is_shift, is_olc_dec, is_olc_set, is_bad_cls, is_flags;

    assign is_shift   = exec_i && insn_i[20:19] == 2'b00;
    assign is_olc_set = exec_i && insn_i[20:19] == 2'b10 && insn_i[18:15] == 4'b1000;
    assign is_olc_dec = is_olc_set && insn_i[14:12] == 3'b001;
    assign is_bad_cls = exec_i && insn_i[19];
    assign is_flags   = exec_i && insn_i[20:19] == 2'b10 && insn_i[18:15] == 4'b0001;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(olc_o) && $stable(ilc_o) && $stable(ilc_inf_o)
                     && $stable(data_o) && $stable(flag_a_o) && $stable(flag_b_o)));

    // R3
    olc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_olc_dec && olc_o == '0) |=> olc_o == '0);

    // R6
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_shift |=> data_o == {$past(data_o[DL_W-SHIFT_W-1:0]), $past(insn_i[SHIFT_W-1:0])});

    // R8
    bad_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_bad_cls |=> ($stable(olc_o) && $stable(ilc_o) && $stable(ilc_inf_o)
                        && $stable(data_o) && $stable(flag_a_o) && $stable(flag_b_o)));

    // R9
    olc_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_olc_set |=> ($stable(ilc_o) && $stable(ilc_inf_o) && $stable(data_o)
                        && $stable(flag_a_o) && $stable(flag_b_o)));

    // R9
    flags_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_flags |=> ($stable(olc_o) && $stable(ilc_o) && $stable(ilc_inf_o) && $stable(data_o)));

    // R7
    flag_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_flags && insn_i[11:0] == '0 && !flag_c_i) |=> (!flag_a_o && !flag_b_o));

endmodule

bind dock_exec_top dock_exec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_i   (exec_i),
    .insn_i   (insn_i),
    .flag_c_i (flag_c_i),
    .olc_o    (olc_o),
    .ilc_o    (ilc_o),
    .ilc_inf_o(ilc_inf_o),
    .data_o   (data_o),
    .flag_a_o (flag_a_o),
    .flag_b_o (flag_b_o)
);

// File: tb/tb_dock_exec_top.sv
module tb_dock_exec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [25:0] insn_i = '0;
    logic        flag_c_i = 1'b0;
    logic [5:0]  olc_o, ilc_o;
    logic        ilc_inf_o, flag_a_o, flag_b_o;
    logic [36:0] data_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural model state
    int          m_olc, m_ilc;
    bit          m_inf, m_a, m_b;
    logic [36:0] m_dl;

    always #10 clk = ~clk;

    dock_exec_top dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .insn_i(insn_i),
        .flag_c_i(flag_c_i), .olc_o(olc_o), .ilc_o(ilc_o), .ilc_inf_o(ilc_inf_o),
        .data_o(data_o), .flag_a_o(flag_a_o), .flag_b_o(flag_b_o)
    );

    function automatic logic [25:0] mk_set(input logic [3:0] dest, input logic [2:0] src,
                                           input logic [11:0] low);
        return {5'b00000, 2'b10, dest, src, low};
    endfunction

    function automatic logic [25:0] mk_shift(input logic [18:0] imm);
        return {5'b00000, 2'b00, imm};
    endfunction

    function automatic bit pick(input logic [5:0] m, input bit a, input bit b, input bit c);
        bit r;
        r = 1'b0;
        if (m[0] && a)  r = 1'b1;
        if (m[1] && !a) r = 1'b1;
        if (m[2] && b)  r = 1'b1;
        if (m[3] && !b) r = 1'b1;
        if (m[4] && c)  r = 1'b1;
        if (m[5] && !c) r = 1'b1;
        return r;
    endfunction

    task automatic model_apply(input bit ex, input logic [25:0] w, input bit c);
        bit na, nb;
        if (!ex) return;
        if (w[20:19] == 2'b00) begin
            m_dl = {m_dl[17:0], w[18:0]};
        end else if (w[20:19] == 2'b10) begin
            case (w[18:15])
                4'b1000: begin
                    if (w[14:12] == 3'b100) m_olc = w[5:0];
                    else if (w[14:12] == 3'b010) m_olc = m_dl[5:0];
                    else if (w[14:12] == 3'b001) m_olc = (m_olc > 0) ? m_olc - 1 : 0;
                end
                4'b0100: begin
                    if (w[14:12] == 3'b100) begin
                        if (w[6]) m_inf = 1'b1;
                        else begin m_ilc = w[5:0]; m_inf = 1'b0; end
                    end else if (w[14:12] == 3'b010) begin
                        m_ilc = m_dl[5:0]; m_inf = 1'b0;
                    end
                end
                4'b0010: m_dl = {{23{w[14]}}, w[13:0]};
                4'b0001: begin
                    na = pick(w[11:6], m_a, m_b, c);
                    nb = pick(w[5:0], m_a, m_b, c);
                    m_a = na; m_b = nb;
                end
                default: ;
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [36:0] act,
                       input logic [36:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "olc", 37'(olc_o), 37'(m_olc));
        chk(tag, "ilc", 37'(ilc_o), 37'(m_ilc));
        chk(tag, "ilc_inf", 37'(ilc_inf_o), 37'(m_inf));
        chk(tag, "data", data_o, m_dl);
        chk(tag, "flag_a", 37'(flag_a_o), 37'(m_a));
        chk(tag, "flag_b", 37'(flag_b_o), 37'(m_b));
    endtask

    task automatic step(input string tag, input bit ex, input logic [25:0] w, input bit c);
        @(negedge clk);
        exec_i = ex; insn_i = w; flag_c_i = c;
        model_apply(ex, w, c);
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_olc = 0; m_ilc = 0; m_inf = 0; m_a = 0; m_b = 0; m_dl = '0;
        // R1: reset while an instruction is offered
        rst_n = 1'b0; exec_i = 1'b1; insn_i = mk_set(4'b0010, 3'b111, 12'hFFF);
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1; exec_i = 1'b0;

        // R5: zero and one extension
        step("R5", 1, mk_set(4'b0010, 3'b010, 12'hABC), 0);
        chk("R5", "zero-ext", data_o, 37'h0000002ABC);
        step("R5", 1, mk_set(4'b0010, 3'b101, 12'h123), 0);
        chk("R5", "one-ext", data_o, {23'h7FFFFF, 14'h1123});
        // R6: two shifts
        step("R6", 1, mk_shift(19'h5A5A5), 0);
        step("R6", 1, mk_shift(19'h12345), 0);
        // R3: immediate, decrement to zero and past it, load from latch
        step("R3", 1, mk_set(4'b1000, 3'b100, 12'h002), 0);
        step("R3", 1, mk_set(4'b1000, 3'b001, 12'h000), 0);
        step("R3", 1, mk_set(4'b1000, 3'b001, 12'h000), 0);
        step("R3", 1, mk_set(4'b1000, 3'b001, 12'h000), 0);
        chk("R3", "floor", 37'(olc_o), 37'd0);
        step("R3", 1, mk_set(4'b1000, 3'b010, 12'h000), 0);
        // R4: immediate, infinity, from latch
        step("R4", 1, mk_set(4'b0100, 3'b100, 12'h02B), 0);
        step("R4", 1, mk_set(4'b0100, 3'b100, 12'h040), 0);
        chk("R4", "inf", 37'(ilc_inf_o), 37'd1);
        step("R4", 1, mk_set(4'b0100, 3'b010, 12'h000), 0);
        step("R4", 1, mk_set(4'b0100, 3'b100, 12'h07F), 0);
        step("R4", 1, mk_set(4'b0100, 3'b100, 12'h011), 0);
        // R7: flag masks; A <- not A (1), B <- old A (0) then swaps
        step("R7", 1, mk_set(4'b0001, 3'b000, {6'b000010, 6'b000001}), 0);
        step("R7", 1, mk_set(4'b0001, 3'b000, {6'b000100, 6'b000001}), 0);
        step("R7", 1, mk_set(4'b0001, 3'b000, {6'b010000, 6'b100000}), 1);
        step("R7", 1, mk_set(4'b0001, 3'b000, {6'b001000, 6'b000010}), 0);
        step("R7", 1, mk_set(4'b0001, 3'b000, 12'h000), 0);
        // R2: no execute
        step("R2", 0, mk_set(4'b0010, 3'b111, 12'hFFF), 1);
        step("R2", 0, mk_shift(19'h7FFFF), 0);
        // R8: unsupported encodings
        step("R8", 1, {5'b0, 2'b01, 19'h7FFFF}, 0);
        step("R8", 1, {5'b0, 2'b11, 19'h2AAAA}, 0);
        step("R8", 1, mk_set(4'b1100, 3'b100, 12'h015), 0);
        step("R8", 1, mk_set(4'b0000, 3'b100, 12'h015), 0);
        step("R8", 1, mk_set(4'b1000, 3'b011, 12'h015), 0);
        step("R8", 1, mk_set(4'b0100, 3'b001, 12'h015), 0);
        // R9: single destination
        step("R9", 1, mk_set(4'b1000, 3'b100, 12'h03C), 1);
        step("R9", 1, mk_set(4'b0010, 3'b000, 12'h555), 1);
        // R10: header bits
        step("R10", 1, mk_set(4'b1000, 3'b100, 12'h009) | 26'h3E00000, 0);
        step("R10", 1, mk_shift(19'h0F0F0) | 26'h2A00000, 0);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [25:0] w;
            logic [3:0] d;
            w = 26'($urandom);
            d = 4'b0001 << ($urandom % 4);
            if (($urandom % 4) != 0) begin
                w[20:19] = 2'b10; w[18:15] = d;
                if (($urandom % 2) != 0) w[14:12] = 3'b100 >> ($urandom % 3);
            end
            step("R9", ($urandom % 5) != 0, w, 1'($urandom));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule